// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers twenty interrupt sources into one decision for a processor. Twelve come from external pins. Four are raised by writes to message registers. Four come from built-in reload timers. Each source carries its own configuration:

- a 4-bit priority;
- a mask bit;
- a routing bit that selects the standard or the critical interrupt output;
- for the external pins only, a choice between edge and level sensing.

On every cycle the controller finds the strongest pending, unmasked source. It presents that source only if its priority beats the processor's task priority and also beats the highest priority that is currently in service.

Software works through a small word-addressed register bus. Reads are combinational. A read is qualified by `bus_rd`, and a write is performed on the clock edge while `bus_wr` is high. Reading the acknowledge register returns the winning source number and has side effects on the following clock edge:

- the winner's priority level is marked in service;
- the winner's pending bit is cleared if the source is edge-sensed.

Writing the end-of-interrupt register retires the highest in-service level. These two registers together give fully nested delivery: a stronger source can interrupt a handler, while equal or weaker sources wait until end-of-interrupt.

Word map:

| Address | Register |
|---|---|
| 0x00 to 0x13 | Per-source configuration, one word per source |
| 0x20 | Task priority |
| 0x21 | Acknowledge |
| 0x22 | End-of-interrupt |
| 0x23 | Pending summary |
| 0x24 to 0x27 | Message registers |
| 0x28 to 0x2B | Timer reload registers |

Source numbering:

| Sources | Origin |
|---|---|
| 0 to 11 | External pins |
| 12 to 15 | Message registers 0 to 3 |
| 16 to 19 | Timers 0 to 3 |

Top module: `nested_irq_ctrl`

## Requirements
- R1: Each source has a priority from 0 to 15 in bits [3:0] of its configuration word. The task priority register holds a value from 0 to 15. A source is presented only when its priority is strictly greater than the task priority.
- R2: External pins 0 to 11 feed sources 0 to 11. Configuration bit 10 selects sensing: 0 means rising edge, 1 means level. An edge source latches pending on a rising edge and holds it, and a pin held high raises only one event. A level source's pending bit follows the pin one cycle later, and acknowledge does not clear it.
- R3: A write to message register k (address 0x24+k) stores the 32-bit word and sets the pending bit of source 12+k. Reading that address returns the stored word.
- R4: Timer k has a reload register at address 0x28+k. Writing a nonzero value R makes source 16+k pending R cycles after the write, and again every R cycles after that. Writing 0 stops the timer. Reading the address returns the reload value.
- R5: Acknowledge marks the winner's priority level in service. While a level is in service, only strictly higher priorities are presented. A write to address 0x22 retires the highest in-service level. End-of-interrupt with nothing in service changes nothing.
- R6: Configuration bit 9 routes a presented source: 1 selects `irq_crit`, 0 selects `irq_std`. Both outputs are never high together.
- R7: Address 0x23 reads the pending bits of all sources, with bit i belonging to source i.
- R8: A read of address 0x21 with `bus_rd` high returns the presented source number and clears its edge pending bit. When nothing is presented, the read returns 0xFF and changes no state.
- R9: A higher priority beats a lower one. Among equal priorities, the lowest source number wins.
- R10: Configuration bit 8 masks a source. A masked source still becomes pending and shows in the summary, but it is never presented or acknowledged.
- R11: After synchronous reset the following all hold:
  - every source is masked, with priority 0, edge sensing and standard routing;
  - the task priority is 0;
  - nothing is pending;
  - nothing is in service;
  - both outputs are low.
- R12: If an acknowledge clears a source's pending bit in the same cycle that a new event arrives for that source, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq | input | 12 | External interrupt pins |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; needed for acknowledge side effects |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_std | output | 1 | Standard interrupt request |
| irq_crit | output | 1 | Critical interrupt request |

## Verification
Two functions can act on the same pending bit in one cycle:

- the acknowledge read, which clears the bit;
- a fresh rising edge on that same external pin, which sets it.

The bench provokes this by driving the acknowledge read and the pin's rising edge on the same clock edge. It then judges the outcome in two ways:

- the summary register must still show the source pending after that edge;
- after end-of-interrupt, a second acknowledge must return the same source number.

The bench also drives several sources together, at varied priorities, against the task threshold and the in-service level. This checks that selection and nesting resolve the same way as the requirements state.

// File: rtl/nic_pkg.sv
`timescale 1ns/1ps
package nic_pkg;
    localparam int PRIO_W   = 4;
    localparam int N_EXT    = 12;
    localparam int N_MSG    = 4;
    localparam int N_TMR    = 4;
    localparam int N_SRC    = N_EXT + N_MSG + N_TMR;
    localparam int SRC_W    = $clog2(N_SRC);
    localparam int MSG_BASE = N_EXT;
    localparam int TMR_BASE = N_EXT + N_MSG;
    localparam int ADDR_W   = 6;
    localparam int TMR_W    = 16;

    localparam logic [ADDR_W-1:0] A_TPR = 6'h20;
    localparam logic [ADDR_W-1:0] A_ACK = 6'h21;
    localparam logic [ADDR_W-1:0] A_EOI = 6'h22;
    localparam logic [ADDR_W-1:0] A_SUM = 6'h23;
    localparam logic [ADDR_W-1:0] A_MSG = 6'h24;
    localparam logic [ADDR_W-1:0] A_TMR = 6'h28;
    localparam logic [7:0]        SPURIOUS = 8'hFF;

    typedef struct packed {
        logic              level;
        logic              crit;
        logic              mask;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

    typedef struct packed {
        logic              found;
        logic [SRC_W-1:0]  idx;
        logic [PRIO_W-1:0] prio;
    } win_t;

    localparam src_cfg_t CFG_RESET = '{level: 1'b0, crit: 1'b0, mask: 1'b1, prio: '0};

    function automatic src_cfg_t word_to_cfg(input logic [31:0] w);
        src_cfg_t c;
        c.prio  = w[PRIO_W-1:0];
        c.mask  = w[8];
        c.crit  = w[9];
        c.level = w[10];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input src_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[PRIO_W-1:0] = c.prio;
        w[8]  = c.mask;
        w[9]  = c.crit;
        w[10] = c.level;
        return w;
    endfunction
endpackage

// File: rtl/nic_arbiter.sv
`timescale 1ns/1ps
module nic_arbiter
    import nic_pkg::*;
(
    input  logic [N_SRC-1:0]             elig,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
    output win_t                         win
);
    // Ascending scan with a strict compare: ties keep the lower index (R9)
    always_comb begin
        win = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (!win.found || prio[i] > win.prio)) begin
                win.found = 1'b1;
                win.idx   = SRC_W'(i);
                win.prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/nic_nest.sv
`timescale 1ns/1ps
module nic_nest
    import nic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_lvl,
    input  logic              pop,
    output logic              any,
    output logic [PRIO_W-1:0] top
);
    localparam int NLVL = 1 << PRIO_W;

    logic [NLVL-1:0] isr_q, isr_d;

    always_comb begin
        any = |isr_q;
        top = '0;
        for (int l = 0; l < NLVL; l++)
            if (isr_q[l]) top = PRIO_W'(l);
    end

    always_comb begin
        isr_d = isr_q;
        if (pop && any) isr_d[top] = 1'b0;
        if (push)       isr_d[push_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= isr_d;
    end

    AST_PUSH_MARKS: assert property (@(posedge clk) disable iff (rst)
        push |=> isr_q[$past(push_lvl)]); // R5
    AST_POP_RETIRES_ONE: assert property (@(posedge clk) disable iff (rst)
        (pop && any && !push) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R5
    AST_POP_EMPTY_NOP: assert property (@(posedge clk) disable iff (rst)
        (pop && !any && !push) |=> (isr_q == '0)); // R5
endmodule

// File: rtl/nic_timer.sv
`timescale 1ns/1ps
module nic_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         fire,
    output logic [W-1:0] reload
);
    logic [W-1:0] cnt_q, reload_q;

    assign reload = reload_q;
    assign fire   = (reload_q != '0) && (cnt_q == W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            reload_q <= '0;
        end else if (load) begin
            cnt_q    <= load_val;
            reload_q <= load_val;
        end else if (reload_q != '0) begin
            cnt_q <= (cnt_q == W'(1)) ? reload_q : cnt_q - W'(1);
        end
    end

    AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (fire && !load) |=> (cnt_q == $past(reload_q))); // R4
    AST_TMR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (reload_q == '0) |-> !fire); // R4
endmodule

// File: rtl/nested_irq_ctrl.sv
`timescale 1ns/1ps
module nested_irq_ctrl
    import nic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EXT-1:0]  ext_irq,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_std,
    output logic              irq_crit
);
    src_cfg_t                     cfg_q [N_SRC];
    logic [PRIO_W-1:0]            tpr_q;
    logic [31:0]                  msg_q [N_MSG];
    logic [N_EXT-1:0]             ext_prev_q;
    logic [N_SRC-1:0]             pend_q, pend_d;
    logic [N_SRC-1:0]             set_ev, ack_clr, elig, mask_vec, level_vec, ext_pad;
    logic [N_SRC-1:0][PRIO_W-1:0] prio_vec;
    logic [N_MSG-1:0]             msg_wr;
    logic [N_TMR-1:0]             tmr_wr, tmr_fire;
    logic [N_TMR-1:0][TMR_W-1:0]  tmr_reload;
    win_t                         win;
    logic                         isr_any, present, ack_take, eoi;
    logic [PRIO_W-1:0]            isr_top;

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SRC; i++) cfg_q[i] <= CFG_RESET;
            tpr_q <= '0;
        end else if (bus_wr) begin
            for (int i = 0; i < N_SRC; i++) begin
                if (bus_addr == ADDR_W'(i)) begin
                    cfg_q[i] <= word_to_cfg(bus_wdata);
                    if (i >= N_EXT) cfg_q[i].level <= 1'b0;
                end
            end
            if (bus_addr == A_TPR) tpr_q <= bus_wdata[PRIO_W-1:0];
        end
    end

    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            mask_vec[i]  = cfg_q[i].mask;
            level_vec[i] = cfg_q[i].level;
            prio_vec[i]  = cfg_q[i].prio;
        end
    end

    // ---------------- message registers ----------------
    always_comb begin
        for (int k = 0; k < N_MSG; k++)
            msg_wr[k] = bus_wr && (bus_addr == A_MSG + ADDR_W'(k));
        for (int k = 0; k < N_TMR; k++)
            tmr_wr[k] = bus_wr && (bus_addr == A_TMR + ADDR_W'(k));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N_MSG; k++) msg_q[k] <= '0;
        end else begin
            for (int k = 0; k < N_MSG; k++)
                if (msg_wr[k]) msg_q[k] <= bus_wdata;
        end
    end

    // ---------------- timers ----------------
    for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
        nic_timer #(.W(TMR_W)) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .load     (tmr_wr[k]),
            .load_val (bus_wdata[TMR_W-1:0]),
            .fire     (tmr_fire[k]),
            .reload   (tmr_reload[k])
        );
    end

    // ---------------- pending latch ----------------
    assign ext_pad = N_SRC'(ext_irq);

    always_comb begin
        set_ev = '0;
        set_ev[N_EXT-1:0]          = ext_irq & ~ext_prev_q;
        set_ev[MSG_BASE +: N_MSG]  = msg_wr;
        set_ev[TMR_BASE +: N_TMR]  = tmr_fire;
        ack_clr = ack_take ? (N_SRC'(1) << win.idx) : '0;
        for (int i = 0; i < N_SRC; i++)
            pend_d[i] = level_vec[i] ? ext_pad[i]
                                     : ((pend_q[i] & ~ack_clr[i]) | set_ev[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= '0;
            ext_prev_q <= '0;
        end else begin
            pend_q     <= pend_d;
            ext_prev_q <= ext_irq;
        end
    end

    // ---------------- selection and nesting ----------------
    assign elig = pend_q & ~mask_vec;

    nic_arbiter u_arb (
        .elig (elig),
        .prio (prio_vec),
        .win  (win)
    );

    assign ack_take = bus_rd && (bus_addr == A_ACK) && present;
    assign eoi      = bus_wr && (bus_addr == A_EOI);

    nic_nest u_nest (
        .clk      (clk),
        .rst      (rst),
        .push     (ack_take),
        .push_lvl (win.prio),
        .pop      (eoi),
        .any      (isr_any),
        .top      (isr_top)
    );

    assign present  = win.found && (win.prio > tpr_q) && (!isr_any || win.prio > isr_top);
    assign irq_std  = present && !cfg_q[win.idx].crit;
    assign irq_crit = present &&  cfg_q[win.idx].crit;

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(N_SRC)) begin
            bus_rdata = cfg_to_word(cfg_q[bus_addr[SRC_W-1:0]]);
        end else if (bus_addr == A_TPR) begin
            bus_rdata = 32'(tpr_q);
        end else if (bus_addr == A_ACK) begin
            bus_rdata = present ? 32'(win.idx) : 32'(SPURIOUS);
        end else if (bus_addr == A_SUM) begin
            bus_rdata = 32'(pend_q);
        end else begin
            for (int k = 0; k < N_MSG; k++)
                if (bus_addr == A_MSG + ADDR_W'(k)) bus_rdata = msg_q[k];
            for (int k = 0; k < N_TMR; k++)
                if (bus_addr == A_TMR + ADDR_W'(k)) bus_rdata = 32'(tmr_reload[k]);
        end
    end

    // ---------------- assertions ----------------
    AST_ABOVE_TASK: assert property (@(posedge clk) disable iff (rst)
        (irq_std || irq_crit) |-> (win.prio > tpr_q)); // R1
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (irq_std || irq_crit) |-> !cfg_q[win.idx].mask); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack_take && !level_vec[win.idx] && !set_ev[win.idx]) |=> !pend_q[$past(win.idx)]); // R8
    AST_ACK_RACE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (ack_take && !level_vec[win.idx] && set_ev[win.idx]) |=> pend_q[$past(win.idx)]); // R12
    for (genvar k = 0; k < N_MSG; k++) begin : g_msg_chk
        AST_MSG_RAISES: assert property (@(posedge clk) disable iff (rst)
            msg_wr[k] |=> pend_q[MSG_BASE + k]); // R3
    end
endmodule

// File: tb/tb_nested_irq_ctrl.sv
`timescale 1ns/1ps
module tb_nested_irq_ctrl;
    import nic_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] ext_irq = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_std, irq_crit;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    nested_irq_ctrl dut (
        .clk(clk), .rst(rst), .ext_irq(ext_irq), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_std(irq_std), .irq_crit(irq_crit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cfg(input int src, input int prio, input bit mask, input bit crit, input bit lvl);
        wr(6'(src), {21'b0, lvl, crit, mask, 4'b0, 4'(prio)});
    endtask

    task automatic pulse(input logic [11:0] m);
        @(negedge clk); ext_irq = ext_irq | m;
        @(negedge clk); ext_irq = ext_irq & ~m;
    endtask

    task automatic ack_is(input string tag, input int exp);
        logic [31:0] v;
        rd(A_ACK, v);
        chk(tag, v, 32'(exp));
    endtask

    task automatic eoi();
        wr(A_EOI, 32'h0);
    endtask

    task automatic outs_are(input string tag, input logic [1:0] exp);
        @(negedge clk);
        #1 chk(tag, 32'({irq_crit, irq_std}), 32'(exp));
    endtask

    task automatic sum_bit(input string tag, input int b, input bit exp);
        logic [31:0] v;
        peek(A_SUM, v);
        chk(tag, 32'(v[b]), 32'(exp));
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        peek(A_SUM, v);     chk("R11 summary", v, 32'h0);
        peek(6'h00, v);     chk("R11 cfg0", v, 32'h100);
        peek(6'h13, v);     chk("R11 cfg19", v, 32'h100);
        peek(A_TPR, v);     chk("R11 tpr", v, 32'h0);
        outs_are("R11 outputs", 2'b00);
        ack_is("R11 ack spurious", 8'hFF);

        // R1 priority against task threshold, full sweep
        for (int p = 0; p < 16; p++) begin
            cfg(0, p, 0, 0, 0);
            pulse(12'h001);
            for (int t = 0; t < 16; t++) begin
                wr(A_TPR, 32'(t));
                outs_are("R1 threshold", {1'b0, (p > t)});
            end
            wr(A_TPR, 32'h0);
            if (p > 0) begin
                ack_is("R1 ack", 0);
                eoi();
            end
        end
        cfg(0, 0, 1, 0, 0);

        // R9 priority order and ties
        for (int a = 1; a <= 4; a++)
            for (int b = 1; b <= 4; b++)
                for (int pa = 3; pa <= 7; pa += 4)
                    for (int pb = 3; pb <= 7; pb += 4) begin
                        if (a != b) begin
                            int w, o;
                            w = (pa > pb || (pa == pb && a < b)) ? a : b;
                            o = (w == a) ? b : a;
                            cfg(a, pa, 0, 0, 0);
                            cfg(b, pb, 0, 0, 0);
                            pulse(12'(1 << a) | 12'(1 << b));
                            ack_is("R9 first winner", w);
                            eoi();
                            ack_is("R9 second winner", o);
                            eoi();
                            cfg(a, 0, 1, 0, 0);
                            cfg(b, 0, 1, 0, 0);
                        end
                    end

        // R10 mask
        cfg(5, 9, 1, 0, 0);
        pulse(12'h020);
        sum_bit("R10 masked pending", 5, 1'b1);
        outs_are("R10 masked silent", 2'b00);
        ack_is("R10 masked ack", 8'hFF);
        cfg(5, 9, 0, 0, 0);
        outs_are("R10 unmasked", 2'b01);
        ack_is("R10 ack", 5);
        eoi();
        cfg(5, 0, 1, 0, 0);

        // R6 critical routing
        cfg(6, 5, 0, 1, 0);
        pulse(12'h040);
        outs_are("R6 critical", 2'b10);
        ack_is("R6 ack", 6);
        outs_are("R6 after ack", 2'b00);
        eoi();
        cfg(6, 0, 1, 0, 0);

        // R5 nesting
        cfg(7, 4, 0, 0, 0);
        cfg(8, 10, 0, 0, 0);
        cfg(9, 4, 0, 0, 0);
        pulse(12'h080);
        ack_is("R5 first", 7);
        pulse(12'h200);
        outs_are("R5 equal blocked", 2'b00);
        pulse(12'h100);
        outs_are("R5 preempt", 2'b01);
        ack_is("R5 nested ack", 8);
        outs_are("R5 top busy", 2'b00);
        eoi();
        outs_are("R5 still level 4", 2'b00);
        eoi();
        outs_are("R5 released", 2'b01);
        ack_is("R5 deferred", 9);
        eoi();
        eoi();
        outs_are("R5 empty eoi", 2'b00);
        sum_bit("R5 nothing left", 9, 1'b0);
        cfg(7, 0, 1, 0, 0); cfg(8, 0, 1, 0, 0); cfg(9, 0, 1, 0, 0);

        // R2 level and edge sensing
        cfg(10, 6, 0, 0, 1);
        @(negedge clk); ext_irq[10] = 1'b1;
        sum_bit("R2 level pending", 10, 1'b1);
        ack_is("R2 level ack", 10);
        sum_bit("R2 level kept", 10, 1'b1);
        eoi();
        @(negedge clk); ext_irq[10] = 1'b0;
        sum_bit("R2 level drop", 10, 1'b0);
        cfg(10, 0, 1, 0, 0);
        cfg(11, 6, 0, 0, 0);
        @(negedge clk); ext_irq[11] = 1'b1;
        ack_is("R2 edge ack", 11);
        eoi();
        sum_bit("R2 held no retrigger", 11, 1'b0);
        @(negedge clk); ext_irq[11] = 1'b0;
        cfg(11, 0, 1, 0, 0);

        // R3 message registers, R7 summary
        for (int k = 0; k < 4; k++) begin
            logic [31:0] val;
            val = 32'hA5000000 | 32'(k * 32'h1111);
            cfg(12 + k, 3, 0, 0, 0);
            wr(A_MSG + 6'(k), val);
            peek(A_SUM, v);
            chk("R7 R3 summary", v, 32'(1 << (12 + k)));
            peek(A_MSG + 6'(k), v);
            chk("R3 readback", v, val);
            ack_is("R3 ack", 12 + k);
            eoi();
            cfg(12 + k, 0, 1, 0, 0);
        end

        // R4 timers
        for (int k = 0; k < 4; k++) begin
            int r;
            r = 4 + k;
            cfg(16 + k, 1, 1, 0, 0);
            wr(A_TMR + 6'(k), 32'(r));
            for (int j = 1; j <= r; j++) begin
                peek(A_SUM, v);
                chk("R4 expiry timing", 32'(v[16 + k]), 32'(j >= r));
            end
            peek(A_TMR + 6'(k), v);
            chk("R4 reload readback", v, 32'(r));
            wr(A_TMR + 6'(k), 32'h0);
            cfg(16 + k, 1, 0, 0, 0);
            ack_is("R4 ack", 16 + k);
            eoi();
            repeat (2 * r) @(negedge clk);
            sum_bit("R4 stopped", 16 + k, 1'b0);
            cfg(16 + k, 0, 1, 0, 0);
        end

        // R12 acknowledge and new edge together
        cfg(0, 8, 0, 0, 0);
        pulse(12'h001);
        @(negedge clk); bus_rd = 1'b1; bus_addr = A_ACK; ext_irq[0] = 1'b1;
        #1 chk("R12 ack vector", bus_rdata, 32'h0);
        @(negedge clk); bus_rd = 1'b0; ext_irq[0] = 1'b0;
        sum_bit("R12 still pending", 0, 1'b1);
        eoi();
        ack_is("R12 second ack", 0);
        eoi();
        sum_bit("R12 cleared", 0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule